// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small group of external interrupt pins and turns their activity into interrupt requests for a processor core. All pins share one 2-bit sense field. The field selects one of four triggers: a low level, any change, a falling edge or a rising edge. Each pin has an enable bit in a mask register and a pending flag in a flag register. Software reaches the mask, the flags and the sense field through a byte-wide register port with write, read, address and data signals.

The block samples the pad value, so activity on a pin that the chip itself drives still raises a request. Every pin passes through a two-flop synchronizer. A previous-value register then feeds the edge detector. In the edge modes, a detected event sets the pin's flag, and the request line is the flag gated by the pin's enable and by the global interrupt enable. In low-level mode the flags are held at zero, and the request follows the synchronized pin directly. A pending flag clears when software writes a one to it, or when the core pulses that pin's acknowledge strobe. The external reset asserts asynchronously, and the block releases it synchronously.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset the mask, flag and sense registers read zero and every request line is low.
- R2: With sense code 01, any change of a pin's level sets that pin's flag (flag register bit 7 for pin 1, bit 6 for pin 0).
- R3: With sense code 10, only a high-to-low transition sets a pin's flag. A rising transition leaves it clear.
- R4: With sense code 11, only a low-to-high transition sets a pin's flag. A falling transition leaves it clear.
- R5: With sense code 00, the flag register reads zero. A pin's request is high while the pin is held low and its enable and the global enable are set.
- R6: In the edge modes a pin's request equals its flag AND its mask enable (mask register bit 7 for pin 1, bit 6 for pin 0) AND the global enable. Clearing either enable drops the request but keeps the flag.
- R7: Writing the flag register clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R8: A one-cycle pulse on a pin's acknowledge input clears that pin's flag only.
- R9: When an event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R10: A pin pulse that lasts at least two clock cycles is detected in the edge modes.
- R11: Register map: address 0 holds the mask, address 1 the flags, address 2 the sense code in bits 1:0, and address 3 is reserved. Unused bits and the reserved address read zero, and the read data is zero while the read strobe is low.
- R12: A pin held high through reset does not produce a spurious edge event, even when an edge mode is selected on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 2 | Pad values of the interrupt pins |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 2 | Per-pin service acknowledge strobes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 2 | Per-pin interrupt request |

## Verification
The hardest case to reach is the start-up window of R12. The synchronizer and previous-value flops come out of reset at zero while the pad is already high. A spurious rising edge could only show if an edge mode were already selected before the detector is primed. The bench reaches this by holding the sense write asserted across the reset release, so the write lands on the first active edge. The same-cycle collisions of R9 also need precise timing: the clear is driven exactly on the edge where the event, delayed by the synchronizer, reaches the flag.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_MASK  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE = 2'd2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o
);

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
  logic [NUM_PINS-1:0] stage_d [SYNC_STAGES];

  always_comb begin
    stage_d[0] = pin_i;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_i,
  input  sense_e              sense_i,
  output logic [NUM_PINS-1:0] evt_o,
  output logic [NUM_PINS-1:0] level_o
);

  localparam int unsigned PRIME_MAX = SYNC_STAGES + 1;
  localparam int unsigned CNT_W     = $clog2(PRIME_MAX + 1);

  logic [CNT_W-1:0]    prime_q;
  logic [CNT_W-1:0]    prime_d;
  logic                prime_en;
  logic                armed_edge;
  logic                armed_level;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] prev_d;

  // Priming counter: edges are trusted once the previous-value register
  // holds a real sample, levels once the synchronizer output does.
  always_comb begin
    prime_en    = (prime_q != CNT_W'(PRIME_MAX));
    prime_d     = prime_q + 1'b1;
    armed_edge  = (prime_q == CNT_W'(PRIME_MAX));
    armed_level = (prime_q >= CNT_W'(SYNC_STAGES));
    prev_d      = sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= '0;
    end else if (prime_en) begin
      prime_q <= prime_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise;
    logic fall;
    logic sel;

    always_comb begin
      rise = sync_i[g] & ~prev_q[g];
      fall = ~sync_i[g] & prev_q[g];
      unique case (sense_i)
        SENSE_ANY:  sel = rise | fall;
        SENSE_FALL: sel = fall;
        SENSE_RISE: sel = rise;
        default:    sel = 1'b0;
      endcase
    end

    assign evt_o[g]   = armed_edge & sel;
    assign level_o[g] = armed_level & ~sync_i[g];

    AST_EVT_NEEDS_NEW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[g] && $stable(sense_i)) |=> (!evt_o[g] || (sync_i[g] != $past(sync_i[g])))); // R2
  end

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_PINS-1:0]   evt_i,
  input  logic [NUM_PINS-1:0]   ack_i,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   flag_o,
  output sense_e                sense_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int unsigned EN_LSB = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] mask_d;
  logic                mask_we;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] flag_d;
  logic [NUM_PINS-1:0] flag_clr;
  logic                flag_wr;
  sense_e              sense_q;
  sense_e              sense_d;
  logic                sense_we;

  always_comb begin
    mask_we  = wr_i && (addr_i == ADDR_MASK);
    flag_wr  = wr_i && (addr_i == ADDR_FLAG);
    sense_we = wr_i && (addr_i == ADDR_SENSE);
    mask_d   = wdata_i[EN_LSB +: NUM_PINS];
    sense_d  = sense_e'(wdata_i[1:0]);
    flag_clr = ack_i | (flag_wr ? wdata_i[EN_LSB +: NUM_PINS] : '0);
    if (sense_q == SENSE_LOW) begin
      flag_d = '0;
    end else begin
      flag_d = (flag_q & ~flag_clr) | evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= SENSE_LOW;
    end else if (sense_we) begin
      sense_q <= sense_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_MASK:  rdata_o[EN_LSB +: NUM_PINS] = mask_q;
        ADDR_FLAG:  rdata_o[EN_LSB +: NUM_PINS] = flag_q;
        ADDR_SENSE: rdata_o[1:0] = sense_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign mask_o  = mask_q;
  assign flag_o  = flag_q;
  assign sense_o = sense_q;

  AST_LEVEL_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q == SENSE_LOW) |=> (flag_q == '0)); // R5

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !evt_i[g]) |=> !flag_q[g]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[g] && sense_q != SENSE_LOW) |=> flag_q[g]); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !ack_i[g] && !(flag_wr && wdata_i[EN_LSB+g]) && sense_q != SENSE_LOW)
      |=> flag_q[g]); // R7
  end

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  gie_i,
  input  logic [NUM_PINS-1:0]   ack_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_PINS-1:0]   irq_o
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic [RST_STAGES-1:0] rst_pipe_d;
  logic                  rst_int_n;
  logic [NUM_PINS-1:0]   sync_w;
  logic [NUM_PINS-1:0]   evt_w;
  logic [NUM_PINS-1:0]   level_w;
  logic [NUM_PINS-1:0]   mask_w;
  logic [NUM_PINS-1:0]   flag_w;
  sense_e                sense_w;

  // Reset: asserted asynchronously, released after RST_STAGES edges.
  always_comb begin
    rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  eirq_sync #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_i),
    .sync_o (sync_w)
  );

  eirq_detect #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) detect_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sync_i  (sync_w),
    .sense_i (sense_w),
    .evt_o   (evt_w),
    .level_o (level_w)
  );

  eirq_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt_w),
    .ack_i   (ack_i),
    .mask_o  (mask_w),
    .flag_o  (flag_w),
    .sense_o (sense_w),
    .rdata_o (reg_rdata_o)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_req
    logic pend;
    always_comb begin
      pend     = (sense_w == SENSE_LOW) ? level_w[g] : flag_w[g];
      irq_o[g] = gie_i & mask_w[g] & pend;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gie_i |-> (irq_o == '0)); // R6

endmodule

// File: tb/ext_irq_sense_ctrl_tb_top.sv
module ext_irq_sense_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin;
  logic       gie;
  logic [1:0] ack;
  logic       wr;
  logic       rd;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .gie_i       (gie),
    .ack_i       (ack),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // {sense, pins before, pins after, expected flags[7:6], expected irq}
  localparam logic [9:0] VEC [12] = '{
    {2'b01, 2'b00, 2'b01, 2'b01, 2'b01},
    {2'b01, 2'b11, 2'b01, 2'b10, 2'b10},
    {2'b01, 2'b01, 2'b10, 2'b11, 2'b11},
    {2'b10, 2'b11, 2'b00, 2'b11, 2'b11},
    {2'b10, 2'b00, 2'b11, 2'b00, 2'b00},
    {2'b10, 2'b11, 2'b10, 2'b01, 2'b01},
    {2'b11, 2'b00, 2'b11, 2'b11, 2'b11},
    {2'b11, 2'b11, 2'b00, 2'b00, 2'b00},
    {2'b11, 2'b01, 2'b11, 2'b10, 2'b10},
    {2'b00, 2'b11, 2'b10, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b11, 2'b00, 2'b00},
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b11}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; pin = 2'b00; gie = 1'b0; ack = 2'b00;
    wr = 1'b0; rd = 1'b0; addr = 2'd0; wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", {6'b0, irq}, 8'h00);

    // R11 register map
    reg_write(2'd0, 8'hFF);
    reg_read(2'd0, d);  chk("R11 mask bits", d, 8'hC0);
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, d);  chk("R11 sense bits", d, 8'h03);
    reg_write(2'd3, 8'hFF);
    reg_read(2'd3, d);  chk("R11 reserved addr", d, 8'h00);
    @(negedge clk); rd = 1'b0; addr = 2'd0; #1;
    chk("R11 no read strobe", rdata, 8'h00);

    // Table walk: R2 R3 R4 R5
    reg_write(2'd0, 8'hC0);
    gie = 1'b1;
    for (int i = 0; i < 12; i++) begin
      reg_write(2'd2, {6'b0, VEC[i][9:8]});
      pin = VEC[i][7:6];
      tick(6);
      reg_write(2'd1, 8'hC0);
      pin = VEC[i][5:4];
      tick(6);
      reg_read(2'd1, d);
      chk($sformatf("R2/R3/R4/R5 vec%0d flags", i), d, {VEC[i][3:2], 6'b0});
      chk($sformatf("R2/R3/R4/R5 vec%0d irq", i), {6'b0, irq}, {6'b0, VEC[i][1:0]});
    end

    // R6 request gating
    reg_write(2'd2, 8'h01);
    pin = 2'b00; tick(6);
    reg_write(2'd1, 8'hC0);
    pin = 2'b01; tick(6);
    chk("R6 irq enabled", {6'b0, irq}, 8'h01);
    gie = 1'b0; tick(1);
    chk("R6 irq gie off", {6'b0, irq}, 8'h00);
    reg_read(2'd1, d); chk("R6 flag kept", d, 8'h40);
    gie = 1'b1;
    reg_write(2'd0, 8'h80); tick(1);
    chk("R6 irq mask off", {6'b0, irq}, 8'h00);
    reg_write(2'd0, 8'hC0); tick(1);
    chk("R6 irq restored", {6'b0, irq}, 8'h01);

    // R7 write-one clear
    pin = 2'b10; tick(6);
    reg_read(2'd1, d); chk("R7 both set", d, 8'hC0);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, d); chk("R7 write zero", d, 8'hC0);
    reg_write(2'd1, 8'h40);
    reg_read(2'd1, d); chk("R7 write one pin0", d, 8'h80);

    // R8 acknowledge
    pin = 2'b01; tick(6);
    reg_read(2'd1, d); chk("R8 both set", d, 8'hC0);
    @(negedge clk); ack = 2'b10;
    @(negedge clk); ack = 2'b00;
    reg_read(2'd1, d); chk("R8 ack pin1", d, 8'h40);

    // R9 set wins over write-one clear (pin0)
    reg_write(2'd1, 8'hC0);
    @(negedge clk); pin[0] = ~pin[0];
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h40;
    @(negedge clk); wr = 1'b0;
    reg_read(2'd1, d); chk("R9 set beats write clear", d, 8'h40);
    // R9 set wins over acknowledge (pin1)
    reg_write(2'd1, 8'hC0);
    @(negedge clk); pin[1] = ~pin[1];
    @(negedge clk);
    @(negedge clk); ack = 2'b10;
    @(negedge clk); ack = 2'b00;
    reg_read(2'd1, d); chk("R9 set beats ack", d, 8'h80);

    // R10 two-cycle pulse in rising mode
    reg_write(2'd2, 8'h03);
    pin = 2'b00; tick(6);
    reg_write(2'd1, 8'hC0);
    @(negedge clk); pin = 2'b01;
    tick(2); pin = 2'b00;
    tick(6);
    reg_read(2'd1, d); chk("R10 short pulse", d, 8'h40);

    // R12 no spurious edge after reset with pins high
    gie = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; pin = 2'b11;
    wr = 1'b1; addr = 2'd2; wdata = 8'h03;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    wr = 1'b0;
    tick(6);
    reg_read(2'd2, d); chk("R12 sense applied", d, 8'h03);
    reg_read(2'd1, d); chk("R12 no spurious flag", d, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule